// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block divides the system clock into time quanta and tracks where the receiver stands inside the current CAN bit. A bit is made of one sync quantum, then segment one (propagation plus first phase), then segment two. At the end of segment one it samples the receive line. When the sampling mode is selected it takes a majority of three line values instead of one. It issues a strobe at each sample and a strobe at the start of each bit, which the transmitter uses as its drive point.

It keeps its phase aligned to the bus using recessive-to-dominant (falling) edges of the receive line. While the bus is idle, such an edge forces a hard synchronization. Otherwise the phase error is corrected by at most the jump width: segment one is lengthened for a late edge, and segment two is shortened for an early edge.

The whole setup comes from one configuration word. Each timing field holds its value minus one. The word is meant to change only while the unit is held in reset.

The line is looked at once per quantum, on the clock where the quantum counter wraps; this is called a quantum tick. Positions inside a bit are counted from 0 (the sync quantum). Segment one therefore covers positions 1..TSEG1, and segment two covers positions TSEG1+1..N-1.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts cfg_word[9:0]+1 clocks, and TSEG1 = cfg_word[19:16]+1, TSEG2 = cfg_word[22:20]+1. While the line holds steady, sample_stb recurs every (cfg_word[9:0]+1)·N clocks, where N = 1+TSEG1+TSEG2.
- R2: sample_stb rises (TSEG1+1) quanta after tx_stb, that is, at the end of position TSEG1. rx_bit changes only in a cycle where sample_stb is high.
- R3: sample_stb and tx_stb are never high in the same cycle. With a quantum longer than one clock, each strobe lasts exactly one clock.
- R4: With bus_idle high, a falling edge first seen at the tick that ends position q raises tx_stb at once. The following sample comes TSEG1 quanta later, whatever happened earlier in the bit.
- R5: With bus_idle low, a falling edge seen at the end of position p, with 1 ≤ p ≤ TSEG1, delays the coming sample by min(p, SJW) quanta, where SJW = cfg_word[15:14]+1. An edge at position 0 changes nothing.
- R6: With bus_idle low, a falling edge seen at the end of position p > TSEG1 shortens the current bit by min(N−p, SJW) quanta.
- R7: At most one resynchronization happens between two samples. A second falling edge in the same bit leaves the timing unchanged.
- R8: With cfg_word[23]=1, rx_bit becomes the majority of the line values at the ticks ending positions TSEG1−2, TSEG1−1 and TSEG1.
- R9: With cfg_word[23]=0, rx_bit becomes the line value at the tick ending position TSEG1.
- R10: During reset, rx_bit is 1 (recessive) and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; the configuration is changed only while it is low |
| cfg_word | input | 24 | Packed timing configuration (minus-one fields, triple-sample select at bit 23) |
| rx_line | input | 1 | Raw receive line, 1 = recessive |
| bus_idle | input | 1 | High while the bus is idle; selects hard synchronization |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | One-clock pulse when rx_bit has just been updated |
| tx_stb | output | 1 | One-clock pulse at the start of each bit |

## Verification
A wrong position counter shows up directly at the ports. The spacing between sample_stb pulses, or between tx_stb and the next sample_stb, moves by whole quanta, and this is visible within one bit time of the fault. A faulty jump-width clamp or a missing one-resync-per-bit guard moves only the sample that follows the edge, so the sweep places a falling edge at every position of the bit for many segment and jump-width settings. A bad vote or history register appears as a wrong rx_bit on the very strobe that follows a one-quantum glitch placed next to the sample point.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   // default field widths of the packed configuration word
   localparam int DEF_BRP_W = 10;
   localparam int DEF_SJW_W = 2;
   localparam int DEF_TS1_W = 4;
   localparam int DEF_TS2_W = 3;

   // default field positions (fixed by the register layout a neighbour writes)
   localparam int DEF_BRP_LSB  = 0;
   localparam int DEF_SJW_LSB  = 14;
   localparam int DEF_TS1_LSB  = 16;
   localparam int DEF_TS2_LSB  = 20;
   localparam int DEF_TRIP_POS = 23;
   localparam int DEF_CFG_W    = 24;

   // width of a position counter able to hold a full bit length
   localparam int DEF_POS_W =
      $clog2(1 + (1 << DEF_TS1_W) + (1 << DEF_TS2_W) + 1);

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
   parameter int BRP_W = can_bt_pkg::DEF_BRP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRP_W-1:0] brp_m1,
   output logic             tq_tick
);

   logic [BRP_W-1:0] div_q;

   assign tq_tick = (div_q == brp_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (tq_tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + BRP_W'(1);
      end
   end

endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tq_tick,
   input  logic rx_line,
   input  logic triple_sel,
   input  logic take,
   output logic rx_bit
);

   logic vote;

   generate
      if (TRIPLE_EN) begin : g_vote3
         // line values seen at the two previous quantum ticks
         logic [1:0] hist_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q <= 2'b11;
            end else if (tq_tick) begin
               hist_q <= {hist_q[0], rx_line};
            end
         end

         assign vote = triple_sel ? can_bt_pkg::maj3(hist_q[1], hist_q[0], rx_line)
                                  : rx_line;
      end else begin : g_vote1
         logic unused_sel;
         assign unused_sel = triple_sel ^ tq_tick;
         assign vote       = rx_line;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_bit <= 1'b1;
      end else if (take) begin
         rx_bit <= vote;
      end
   end

endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer #(
   parameter int SJW_W = can_bt_pkg::DEF_SJW_W,
   parameter int TS1_W = can_bt_pkg::DEF_TS1_W,
   parameter int TS2_W = can_bt_pkg::DEF_TS2_W,
   parameter int POS_W = can_bt_pkg::DEF_POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tq_tick,
   input  logic             rx_line,
   input  logic             bus_idle,
   input  logic [SJW_W-1:0] sjw_m1,
   input  logic [TS1_W-1:0] ts1_m1,
   input  logic [TS2_W-1:0] ts2_m1,
   output logic             take,
   output logic             sample_stb,
   output logic             tx_stb,
   output logic [POS_W-1:0] pos_o,
   output logic [POS_W-1:0] nq_o
);

   localparam logic [POS_W-1:0] ONE = POS_W'(1);

   logic [POS_W-1:0] ts1, ts2, sjw, nq, last;
   logic [POS_W-1:0] pos_q, pos_nx;
   logic [POS_W-1:0] late_corr, early_err, skip_pos;
   logic             rx_prev, sync_done;
   logic             edge_seen, hard_sync, resync, in_ph2;
   logic             bit_start, jump;

   assign ts1  = POS_W'(ts1_m1) + ONE;
   assign ts2  = POS_W'(ts2_m1) + ONE;
   assign sjw  = POS_W'(sjw_m1) + ONE;
   assign nq   = ONE + ts1 + ts2;
   assign last = nq - ONE;

   // falling edge between the previous and the current quantum tick
   assign edge_seen = tq_tick & rx_prev & ~rx_line;
   assign hard_sync = edge_seen & bus_idle;
   assign resync    = edge_seen & ~bus_idle & ~sync_done & (pos_q != '0);
   assign in_ph2    = (pos_q > ts1);

   assign late_corr = (pos_q < sjw) ? pos_q : sjw;
   assign early_err = nq - pos_q;
   assign skip_pos  = pos_q + ONE + sjw;

   always_comb begin
      pos_nx    = pos_q;
      bit_start = 1'b0;
      jump      = 1'b0;
      if (tq_tick) begin
         if (hard_sync) begin
            // quantum holding the edge becomes the sync quantum
            pos_nx    = ONE;
            bit_start = 1'b1;
            jump      = 1'b1;
         end else if (resync && !in_ph2) begin
            // late edge: stretch segment one
            pos_nx = pos_q + ONE - late_corr;
            jump   = 1'b1;
         end else if (resync) begin
            // early edge: cut segment two
            if (early_err <= sjw) begin
               pos_nx    = ONE;
               bit_start = 1'b1;
            end else if (skip_pos == nq) begin
               pos_nx    = '0;
               bit_start = 1'b1;
            end else begin
               pos_nx = skip_pos;
            end
         end else if (pos_q == last) begin
            pos_nx    = '0;
            bit_start = 1'b1;
         end else begin
            pos_nx = pos_q + ONE;
         end
      end
   end

   assign take  = tq_tick & (pos_q == ts1) & ~jump;
   assign pos_o = pos_q;
   assign nq_o  = nq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q      <= '0;
         rx_prev    <= 1'b1;
         sync_done  <= 1'b0;
         sample_stb <= 1'b0;
         tx_stb     <= 1'b0;
      end else begin
         pos_q <= pos_nx;
         if (tq_tick) begin
            rx_prev <= rx_line;
         end
         if (take) begin
            sync_done <= 1'b0;
         end else if (hard_sync || resync) begin
            sync_done <= 1'b1;
         end
         sample_stb <= take;
         tx_stb     <= bit_start;
      end
   end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int CFG_W     = can_bt_pkg::DEF_CFG_W,
   parameter int BRP_W     = can_bt_pkg::DEF_BRP_W,
   parameter int SJW_W     = can_bt_pkg::DEF_SJW_W,
   parameter int TS1_W     = can_bt_pkg::DEF_TS1_W,
   parameter int TS2_W     = can_bt_pkg::DEF_TS2_W,
   parameter int BRP_LSB   = can_bt_pkg::DEF_BRP_LSB,
   parameter int SJW_LSB   = can_bt_pkg::DEF_SJW_LSB,
   parameter int TS1_LSB   = can_bt_pkg::DEF_TS1_LSB,
   parameter int TS2_LSB   = can_bt_pkg::DEF_TS2_LSB,
   parameter int TRIP_POS  = can_bt_pkg::DEF_TRIP_POS,
   parameter bit TRIPLE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             rx_line,
   input  logic             bus_idle,
   output logic             rx_bit,
   output logic             sample_stb,
   output logic             tx_stb
);

   localparam int NQ_MAX = 1 + (1 << TS1_W) + (1 << TS2_W);
   localparam int POS_W  = $clog2(NQ_MAX + 1);

   generate
      if (BRP_LSB + BRP_W > CFG_W) begin : g_bad_brp
         $error("prescaler field exceeds configuration word");
      end
      if (SJW_LSB + SJW_W > CFG_W) begin : g_bad_sjw
         $error("jump width field exceeds configuration word");
      end
      if (TS1_LSB + TS1_W > CFG_W) begin : g_bad_ts1
         $error("segment one field exceeds configuration word");
      end
      if (TS2_LSB + TS2_W > CFG_W) begin : g_bad_ts2
         $error("segment two field exceeds configuration word");
      end
      if (TRIP_POS >= CFG_W) begin : g_bad_trip
         $error("triple-sample select outside configuration word");
      end
      if (SJW_W > TS1_W || SJW_W > TS2_W) begin : g_bad_jump
         $error("jump width field wider than a phase segment field");
      end
      if (POS_W != can_bt_pkg::DEF_POS_W) begin : g_bad_posw
         $error("position width differs from the bound checker width");
      end
   endgenerate

   logic [BRP_W-1:0] brp_m1;
   logic [SJW_W-1:0] sjw_m1;
   logic [TS1_W-1:0] ts1_m1;
   logic [TS2_W-1:0] ts2_m1;
   logic             triple_sel;
   logic             unused_cfg;

   assign brp_m1     = cfg_word[BRP_LSB +: BRP_W];
   assign sjw_m1     = cfg_word[SJW_LSB +: SJW_W];
   assign ts1_m1     = cfg_word[TS1_LSB +: TS1_W];
   assign ts2_m1     = cfg_word[TS2_LSB +: TS2_W];
   assign triple_sel = cfg_word[TRIP_POS];
   assign unused_cfg = ^cfg_word;

   logic             tq_tick;
   logic             take;
   logic [POS_W-1:0] seq_pos;
   logic [POS_W-1:0] seq_nq;

   cbt_prescaler #(.BRP_W(BRP_W)) u_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .brp_m1  (brp_m1),
      .tq_tick (tq_tick)
   );

   cbt_sequencer #(
      .SJW_W (SJW_W),
      .TS1_W (TS1_W),
      .TS2_W (TS2_W),
      .POS_W (POS_W)
   ) u_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tq_tick    (tq_tick),
      .rx_line    (rx_line),
      .bus_idle   (bus_idle),
      .sjw_m1     (sjw_m1),
      .ts1_m1     (ts1_m1),
      .ts2_m1     (ts2_m1),
      .take       (take),
      .sample_stb (sample_stb),
      .tx_stb     (tx_stb),
      .pos_o      (seq_pos),
      .nq_o       (seq_nq)
   );

   cbt_sampler #(.TRIPLE_EN(TRIPLE_EN)) u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .tq_tick    (tq_tick),
      .rx_line    (rx_line),
      .triple_sel (triple_sel),
      .take       (take),
      .rx_bit     (rx_bit)
   );

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
   parameter int POS_W = can_bt_pkg::DEF_POS_W,
   parameter int BRP_W = can_bt_pkg::DEF_BRP_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tq_tick,
   input logic [POS_W-1:0] pos,
   input logic [POS_W-1:0] nq,
   input logic [BRP_W-1:0] brp_m1,
   input logic             sample_stb,
   input logic             tx_stb,
   input logic             rx_bit
);

   assert_sample_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> $past(tq_tick))
      else $error("sample strobe not preceded by a quantum tick");

   assert_tx_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb |-> $past(tq_tick))
      else $error("bit start strobe not preceded by a quantum tick");

   assert_bit_moves_at_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bit != $past(rx_bit)) |-> sample_stb)
      else $error("sampled bit changed without a sample strobe");

   assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && tx_stb))
      else $error("sample and bit start strobes coincide");

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && brp_m1 != '0) |=> !sample_stb)
      else $error("sample strobe longer than one clock");

   assert_pos_in_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pos < nq)
      else $error("position counter left the bit");

endmodule

bind can_bit_timer cbt_checker u_cbt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .tq_tick    (tq_tick),
   .pos        (seq_pos),
   .nq         (seq_nq),
   .brp_m1     (brp_m1),
   .sample_stb (sample_stb),
   .tx_stb     (tx_stb),
   .rx_bit     (rx_bit)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cfg_word = '0;
   logic        rx_line = 1'b1;
   logic        bus_idle = 1'b0;
   logic        rx_bit, sample_stb, tx_stb;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   can_bit_timer u_can_bit_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_word   (cfg_word),
      .rx_line    (rx_line),
      .bus_idle   (bus_idle),
      .rx_bit     (rx_bit),
      .sample_stb (sample_stb),
      .tx_stb     (tx_stb)
   );

   function automatic logic [23:0] mk_cfg(int brp, int sjw, int t1, int t2, bit trip);
      logic [23:0] c;
      c        = '0;
      c[9:0]   = 10'(brp - 1);
      c[15:14] = 2'(sjw - 1);
      c[19:16] = 4'(t1 - 1);
      c[22:20] = 3'(t2 - 1);
      c[23]    = trip;
      return c;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic restart(input logic [23:0] c, input logic rx0, input logic idle);
      @(negedge clk);
      rst_n    = 1'b0;
      cfg_word = c;
      rx_line  = rx0;
      bus_idle = idle;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R10: reset values, and return to them after activity
   task automatic t_reset();
      restart(mk_cfg(1, 1, 2, 2, 1'b0), 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 rx_bit", int'(rx_bit), 1);
      chk("R10 sample_stb", int'(sample_stb), 0);
      chk("R10 tx_stb", int'(tx_stb), 0);
      rst_n = 1'b1;
      repeat (5) step();
      chk("R10 low line sampled", int'(rx_bit), 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 rx_bit after re-reset", int'(rx_bit), 1);
   endtask

   // R1, R2, R3: free-running timing over prescaler and segment settings
   task automatic t_period(input int brp, input int t1, input int t2);
      int n, s1, s2, txb, both, dbl;
      logic prev_s;
      n = 1 + t1 + t2;
      s1 = -1; s2 = -1; txb = -1; both = 0; dbl = 0; prev_s = 1'b0;
      restart(mk_cfg(brp, 1, t1, t2, 1'b0), 1'b1, 1'b0);
      for (int c = 1; c <= brp * (2 * n + t1 + 2); c++) begin
         step();
         if (sample_stb && tx_stb) both++;
         if (sample_stb && prev_s) dbl++;
         prev_s = sample_stb;
         if (tx_stb && s2 < 0) txb = c;
         if (sample_stb) begin
            if (s1 < 0) s1 = c;
            else if (s2 < 0) s2 = c;
         end
      end
      chk("R1 sample spacing", s2 - s1, brp * n);
      chk("R2 tx to sample offset", s2 - txb, brp * (t1 + 1));
      chk("R3 strobes coincide", both, 0);
      if (brp > 1) chk("R3 strobe width", dbl, 0);
   endtask

   // R5, R6: one falling edge at every position of the first bit
   task automatic t_resync(input int t1, input int t2, input int sjw);
      int n;
      n = 1 + t1 + t2;
      for (int q = 0; q < n; q++) begin
         int s1, s2, d1, d2;
         string rq;
         s1 = -1; s2 = -1; d1 = 0; d2 = 0; rq = "R5";
         restart(mk_cfg(1, sjw, t1, t2, 1'b0), 1'b1, 1'b0);
         for (int k = 1; k <= 2 * n + t1 + 4; k++) begin
            rx_line = (k >= q + 1) ? 1'b0 : 1'b1;
            step();
            if (sample_stb) begin
               if (s1 < 0) s1 = k;
               else if (s2 < 0) s2 = k;
            end
         end
         if (q >= 1 && q <= t1) begin
            d1 = (q < sjw) ? q : sjw;
         end else if (q > t1) begin
            d2 = ((n - q) < sjw) ? (n - q) : sjw;
            rq = "R6";
         end
         chk({rq, " first sample"}, s1, t1 + 1 + d1);
         chk({rq, " second sample"}, s2 - s1, n - d2);
      end
   endtask

   // R4: hard synchronization at every position while idle
   task automatic t_hard(input int t1, input int t2);
      int n;
      n = 1 + t1 + t2;
      for (int q = 0; q < n; q++) begin
         int sf, txq;
         sf = -1; txq = 0;
         restart(mk_cfg(1, 1, t1, t2, 1'b0), 1'b1, 1'b1);
         for (int k = 1; k <= q + t1 + 3; k++) begin
            rx_line = (k >= q + 1) ? 1'b0 : 1'b1;
            step();
            if (k == q + 1) txq = int'(tx_stb);
            if (sample_stb && k >= q + 1 && sf < 0) sf = k;
         end
         chk("R4 sample after hard sync", sf, q + 1 + t1);
         chk("R4 bit start at edge", txq, 1);
      end
   endtask

   // R7: second falling edge in the same bit is ignored
   task automatic t_once();
      int sf;
      sf = -1;
      restart(mk_cfg(1, 4, 7, 3, 1'b0), 1'b1, 1'b0);
      for (int k = 1; k <= 14; k++) begin
         rx_line = (k == 1 || k == 3) ? 1'b1 : 1'b0;
         step();
         if (sample_stb && sf < 0) sf = k;
      end
      chk("R7 one resync per bit", sf, 9);
   endtask

   // R8, R9: vote with TSEG1 = 5, sample at tick 6
   task automatic t_vote(input bit trip, input int pat, input int exp);
      string rq;
      rq = trip ? "R8" : "R9";
      restart(mk_cfg(1, 1, 5, 3, trip), 1'b0, 1'b0);
      for (int k = 1; k <= 6; k++) begin
         case (pat)
            1:       rx_line = (k == 6) ? 1'b1 : 1'b0;
            2:       rx_line = (k >= 5) ? 1'b1 : 1'b0;
            default: rx_line = 1'b0;
         endcase
         step();
      end
      chk({rq, " strobe at sample point"}, int'(sample_stb), 1);
      chk({rq, " sampled value"}, int'(rx_bit), exp);
   endtask

   initial begin
      t_reset();
      for (int b = 0; b < 4; b++) begin
         int brp;
         brp = (b == 3) ? 5 : b + 1;
         t_period(brp, 3, 2);
         t_period(brp, 1, 1);
         t_period(brp, 16, 8);
      end
      for (int a = 0; a < 4; a++) begin
         for (int c = 0; c < 3; c++) begin
            for (int j = 0; j < 3; j++) begin
               int t1, t2, sj;
               t1 = (a == 0) ? 1 : (a == 1) ? 2 : (a == 2) ? 5 : 16;
               t2 = (c == 0) ? 1 : (c == 1) ? 3 : 8;
               sj = (j == 0) ? 1 : (j == 1) ? 2 : 4;
               t_resync(t1, t2, sj);
            end
         end
      end
      t_hard(5, 4);
      t_hard(2, 3);
      t_once();
      t_vote(1'b1, 0, 0);
      t_vote(1'b1, 1, 0);
      t_vote(1'b1, 2, 1);
      t_vote(1'b0, 0, 0);
      t_vote(1'b0, 1, 1);
      t_vote(1'b0, 2, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule